// File: doc/BRIEF.md
# Phase-Accumulator Carrier Oscillator

This block is a numerically controlled oscillator. It produces a sampled cosine carrier and a sampled sine carrier from a running phase. A phase step word enters a register on every clock. The registered step is added to a stored phase once per cycle, and the sum wraps around at the width of the phase. The wrapped phase addresses two single-cycle waveform tables, one for cosine and one for sine. Each table returns a signed amplitude one clock later. The phase is delayed by the same amount, so the phase and the two amplitudes on the outputs always belong to the same sample.

The output frequency is set by the step word: the output frequency equals the clock rate times the step divided by 256. A transmitter can feed a fixed step and use the two amplitudes as its quadrature carriers. A receiver loop can drive the step from its loop filter and use the block as its controlled oscillator. With the default widths, one phase unit is 1.40625 degrees.

Top module: `nco_carrier_gen`

## Requirements
- R1: While `rst` is high at a rising clock edge (synchronous, active high), the phase register, the step register and all three outputs are cleared to 0. In the first cycle after reset is released, `phase_o`, `cos_o` and `sin_o` all read 0.
- R2: The value on `step_i` at a clock edge is captured into the step register. It is added to the phase at the next edge, and it first changes `phase_o` one edge after that. Changing `step_i` therefore alters the step seen on `phase_o` three edges later.
- R3: On every non-reset clock edge, the stored phase becomes (stored phase + registered step) mod 256. `phase_o` follows the stored phase one cycle later.
- R4: The phase wraps modulo 256: from a phase of 255 with a step of 1, the next phase is 0.
- R5: `cos_o` is the two's complement value round(127·cos(2π·p/256)), where p is the `phase_o` of the same cycle and rounding is half away from zero. For example, phase 0 gives +127 and phase 128 gives −127.
- R6: `sin_o` is round(127·sin(2π·p/256)) for the same p. For example, phase 64 gives +127 and phase 192 gives −127.
- R7: Each table has one cycle of read latency, and `phase_o` is delayed by the same single cycle. From the second cycle after reset, the amplitudes shown in a cycle belong to the `phase_o` shown in that cycle.
- R8: With a step of 0, `phase_o` holds its value on every cycle once the zero step has passed through the step register.
- R9: With a step of 64, the outputs repeat every four samples: phases 0, 64, 128, 192; cosine +127, 0, −127, 0; sine 0, +127, 0, −127.
- R10: Neither amplitude output ever takes the most negative code (−128). Both stay within ±127.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_i | input | 8 | Phase step word, one unit = 360/256 degrees |
| phase_o | output | 8 | Phase aligned with the amplitudes |
| cos_o | output | 8 | Signed cosine sample |
| sin_o | output | 8 | Signed sine sample |

## Verification
In one cycle, the accumulator can take in a new step word while the tables are still reading the address formed from the old step. The bench provokes this by changing `step_i` in the middle of a run. It then checks that `phase_o` moves by the old step for two more samples before the new step appears, while the amplitudes continue to match the phase shown in each cycle. A second collision happens when a reset arrives while the phase and the table outputs are non-zero. The bench checks that all outputs read 0 in the following cycle and that counting starts again from phase 0.

// File: rtl/nco_pkg.sv
package nco_pkg;

   // which waveform a table holds
   typedef enum logic {
      WAVE_COS = 1'b0,
      WAVE_SIN = 1'b1
   } wave_e;

   // read latency of the waveform tables, matched by the phase delay
   localparam int TABLE_LAT = 1;

   localparam real TWO_PI = 6.28318530717958647692;

   // amplitude of one table entry, rounded half away from zero
   function automatic int wave_point(input int idx, input int depth,
                                     input int peak, input wave_e kind);
      real ang;
      real val;
      ang = TWO_PI * real'(idx) / real'(depth);
      if (kind == WAVE_SIN) val = $sin(ang);
      else                  val = $cos(ang);
      val = val * real'(peak);
      if (val >= 0.0) return $rtoi(val + 0.5);
      else            return -$rtoi(0.5 - val);
   endfunction

endpackage

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
   parameter int PHASE_W = 8
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [PHASE_W-1:0] step_i,
   output logic [PHASE_W-1:0] phase_o
);

   logic [PHASE_W-1:0] step_q;
   logic [PHASE_W-1:0] phase_q;
   logic [PHASE_W-1:0] phase_sum;

   // the sum drops its carry, so the phase wraps at 2**PHASE_W
   always_comb begin
      phase_sum = phase_q + step_q;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         step_q  <= '0;
         phase_q <= '0;
      end else begin
         step_q  <= step_i;
         phase_q <= phase_sum;
      end
   end

   assign phase_o = phase_q;

endmodule

// File: rtl/nco_wave_rom.sv
module nco_wave_rom
   import nco_pkg::*;
#(
   parameter int    ADDR_W = 8,
   parameter int    AMP_W  = 8,
   parameter wave_e KIND   = WAVE_COS
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic [ADDR_W-1:0]       addr_i,
   output logic signed [AMP_W-1:0] amp_o
);

   localparam int DEPTH = 1 << ADDR_W;
   localparam int PEAK  = (1 << (AMP_W - 1)) - 1;

   logic signed [AMP_W-1:0] lut [DEPTH];
   logic signed [AMP_W-1:0] amp_q;

   // one full waveform cycle, computed entry by entry at elaboration
   for (genvar g = 0; g < DEPTH; g++) begin : g_entry
      assign lut[g] = AMP_W'(wave_point(g, DEPTH, PEAK, KIND));
   end

   always_ff @(posedge clk) begin
      if (rst) amp_q <= '0;
      else     amp_q <= lut[addr_i];
   end

   assign amp_o = amp_q;

endmodule

// File: rtl/nco_align_pipe.sv
module nco_align_pipe #(
   parameter int W   = 8,
   parameter int LAT = 1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] d_o
);

   if (LAT == 0) begin : g_pass
      assign d_o = d_i;
   end else begin : g_chain
      logic [W-1:0] stage [LAT];
      always_ff @(posedge clk) begin
         if (rst) stage[0] <= '0;
         else     stage[0] <= d_i;
      end
      for (genvar s = 1; s < LAT; s++) begin : g_stage
         always_ff @(posedge clk) begin
            if (rst) stage[s] <= '0;
            else     stage[s] <= stage[s-1];
         end
      end
      assign d_o = stage[LAT-1];
   end

endmodule

// File: rtl/nco_carrier_gen.sv
module nco_carrier_gen
   import nco_pkg::*;
#(
   parameter int PHASE_W = 8,
   parameter int AMP_W   = 8
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic [PHASE_W-1:0]      step_i,
   output logic [PHASE_W-1:0]      phase_o,
   output logic signed [AMP_W-1:0] cos_o,
   output logic signed [AMP_W-1:0] sin_o
);

   // elaboration-time guards on the parameters
   if (PHASE_W < 2 || PHASE_W > 12) begin : g_bad_phase_w
      $error("nco_carrier_gen: PHASE_W must lie in 2..12");
   end
   if (AMP_W < 3 || AMP_W > 16) begin : g_bad_amp_w
      $error("nco_carrier_gen: AMP_W must lie in 3..16");
   end

   logic [PHASE_W-1:0] acc_phase;

   nco_phase_acc #(
      .PHASE_W (PHASE_W)
   ) u_acc (
      .clk     (clk),
      .rst     (rst),
      .step_i  (step_i),
      .phase_o (acc_phase)
   );

   nco_wave_rom #(
      .ADDR_W (PHASE_W),
      .AMP_W  (AMP_W),
      .KIND   (WAVE_COS)
   ) u_cos_rom (
      .clk    (clk),
      .rst    (rst),
      .addr_i (acc_phase),
      .amp_o  (cos_o)
   );

   nco_wave_rom #(
      .ADDR_W (PHASE_W),
      .AMP_W  (AMP_W),
      .KIND   (WAVE_SIN)
   ) u_sin_rom (
      .clk    (clk),
      .rst    (rst),
      .addr_i (acc_phase),
      .amp_o  (sin_o)
   );

   nco_align_pipe #(
      .W   (PHASE_W),
      .LAT (TABLE_LAT)
   ) u_align (
      .clk (clk),
      .rst (rst),
      .d_i (acc_phase),
      .d_o (phase_o)
   );

endmodule

// File: rtl/nco_carrier_gen_chk.sv
module nco_carrier_gen_chk #(
   parameter int PHASE_W = 8,
   parameter int AMP_W   = 8
) (
   input logic                    clk,
   input logic                    rst,
   input logic [PHASE_W-1:0]      step_i,
   input logic [PHASE_W-1:0]      phase_o,
   input logic signed [AMP_W-1:0] cos_o,
   input logic signed [AMP_W-1:0] sin_o
);

   localparam logic signed [AMP_W-1:0] PEAK     = AMP_W'((1 << (AMP_W - 1)) - 1);
   localparam logic signed [AMP_W-1:0] MOST_NEG = {1'b1, {(AMP_W-1){1'b0}}};
   localparam logic [PHASE_W-1:0]      QUARTER  = PHASE_W'(1 << (PHASE_W - 2));

   // cycles since reset, saturating
   logic [2:0] warm;
   always_ff @(posedge clk) begin
      if (rst)               warm <= '0;
      else if (warm != 3'd7) warm <= warm + 3'd1;
   end

   // R1
   reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (phase_o == '0 && cos_o == '0 && sin_o == '0));

   // R3
   phase_step_chk: assert property (@(posedge clk) disable iff (rst)
      (warm >= 3'd3) |-> (phase_o == PHASE_W'($past(phase_o) + $past(step_i, 3))));

   // R8
   freeze_chk: assert property (@(posedge clk) disable iff (rst)
      (warm >= 3'd3 && $past(step_i, 3) == '0) |-> $stable(phase_o));

   // R5
   cos_peak_chk: assert property (@(posedge clk) disable iff (rst)
      (warm >= 3'd1 && phase_o == '0) |-> (cos_o == PEAK && sin_o == '0));

   // R6
   sin_peak_chk: assert property (@(posedge clk) disable iff (rst)
      (warm >= 3'd1 && phase_o == QUARTER) |-> (sin_o == PEAK && cos_o == '0));

   // R10
   amp_range_chk: assert property (@(posedge clk) disable iff (rst)
      (cos_o != MOST_NEG && sin_o != MOST_NEG));

endmodule

bind nco_carrier_gen nco_carrier_gen_chk #(
   .PHASE_W (PHASE_W),
   .AMP_W   (AMP_W)
) u_chk (
   .clk     (clk),
   .rst     (rst),
   .step_i  (step_i),
   .phase_o (phase_o),
   .cos_o   (cos_o),
   .sin_o   (sin_o)
);

// File: tb/nco_carrier_gen_test.sv
module nco_carrier_gen_test;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic [7:0]        step_i = 8'd0;
   logic [7:0]        phase_o;
   logic signed [7:0] cos_o;
   logic signed [7:0] sin_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   nco_carrier_gen uut (
      .clk     (clk),
      .rst     (rst),
      .step_i  (step_i),
      .phase_o (phase_o),
      .cos_o   (cos_o),
      .sin_o   (sin_o)
   );

   // {step, edges after reset release, expected phase}
   localparam int VEC [8][3] = '{
      '{1,   5,   3}, '{64,  6,   0}, '{3,   90,  8},   '{255, 4,  254},
      '{128, 7, 128}, '{0,   10,  0}, '{37,  12,  114}, '{200, 3,  200}
   };

   function automatic int ref_amp(input int p, input bit is_sin);
      real a;
      real v;
      a = 6.28318530717958647692 * real'(p) / 256.0;
      v = 127.0 * (is_sin ? $sin(a) : $cos(a));
      if (v >= 0.0) return $rtoi(v + 0.5);
      else          return -$rtoi(0.5 - v);
   endfunction

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // phase plus both table values for that phase
   task automatic chk_sample(input string req, input int exp_phase);
      chk(req, "phase", int'(phase_o), exp_phase);
      chk(req, "cos", int'(cos_o), ref_amp(exp_phase, 1'b0));
      chk(req, "sin", int'(sin_o), ref_amp(exp_phase, 1'b1));
   endtask

   // reset, then release at a falling edge with the step already applied
   task automatic start(input int step);
      @(negedge clk);
      rst    = 1'b1;
      step_i = 8'(step);
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic advance(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      // R1 reset state
      start(0);
      chk("R1", "phase", int'(phase_o), 0);
      chk("R1", "cos", int'(cos_o), 0);
      chk("R1", "sin", int'(sin_o), 0);

      // table of vectors: R3 phase advance
      for (int v = 0; v < 8; v++) begin
         start(VEC[v][0]);
         advance(VEC[v][1]);
         chk_sample("R3", VEC[v][2]);
      end

      // R2 step latency
      start(5);
      advance(2);
      chk("R2", "phase", int'(phase_o), 0);
      advance(1);
      chk("R2", "phase", int'(phase_o), 5);

      // R2 step changed in mid-run, tables keep up (R7)
      start(10);
      advance(6);
      chk_sample("R2", 40);
      step_i = 8'd1;
      advance(1);
      chk_sample("R7", 50);
      advance(1);
      chk_sample("R2", 60);
      advance(1);
      chk_sample("R2", 61);

      // R8 zero step freezes
      start(7);
      advance(5);
      chk("R8", "phase", int'(phase_o), 21);
      step_i = 8'd0;
      advance(2);
      chk_sample("R8", 35);
      advance(2);
      chk_sample("R8", 35);
      advance(3);
      chk_sample("R8", 35);

      // R9 period of four samples
      begin
         int exp_c [4] = '{127, 0, -127, 0};
         int exp_s [4] = '{0, 127, 0, -127};
         start(64);
         advance(2);
         for (int i = 0; i < 5; i++) begin
            chk("R9", "phase", int'(phase_o), (i * 64) % 256);
            chk("R9", "cos", int'(cos_o), exp_c[i % 4]);
            chk("R9", "sin", int'(sin_o), exp_s[i % 4]);
            advance(1);
         end
      end

      // R5 R6 full table sweep, R4 wrap back to 0, R10 range
      start(1);
      advance(2);
      for (int k = 0; k < 256; k++) begin
         chk_sample("R5", k);
         checks++;
         if (cos_o == -8'sd128 || sin_o == -8'sd128) begin
            fails++;
            $display("FAIL R10 cos=%0d sin=%0d expected within +-127", cos_o, sin_o);
         end
         advance(1);
      end
      chk_sample("R4", 0);
      chk("R6", "sin at 64", ref_amp(64, 1'b1), 127);

      // R1 reset in mid-run clears a busy oscillator
      start(9);
      advance(20);
      rst = 1'b1;
      advance(1);
      rst = 1'b0;
      chk("R1", "phase", int'(phase_o), 0);
      chk("R1", "cos", int'(cos_o), 0);
      chk("R1", "sin", int'(sin_o), 0);
      advance(4);
      chk_sample("R1", 18);

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule